// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous pipelined SRAM that needs no idle cycles when the data bus changes direction. A command is captured on a rising edge. The command carries an address, a write strobe, per-lane write selects, three chip selects, a load/advance control and a burst order. Read data leaves through an output register two enabled clocks later. Write data is taken from the data bus two enabled clocks after its command, which is the same slot a read would use. Because of this, reads and writes can be mixed freely on every clock.

The write address runs through a two-stage command pipeline. The array is read one stage before the data is due. A one-entry record of the last committed write is merged lane by lane into any read of the same address, so a read always returns the newest data. A burst generator can supply up to three more addresses after a load, by stepping the two low address bits in linear or interleaved order. A clock enable freezes the whole block. An output enable only masks the read-valid flag.

Top module: `zt_sram`

## Requirements
- R1: For a read command taken at enabled edge k, rdata holds the word and rd_valid is high after enabled edge k+2.
- R2: For a write command taken at enabled edge k, wdata is sampled at enabled edge k+2. Only the lanes whose bw_n bit is 0 are written. Lane i is wdata[9i+8:9i], and bit 0 of bw_n selects lane 0.
- R3: Reads and writes may be issued on consecutive edges in any order. A read always returns the most recent data, including a write whose data was sampled only one edge before the read's data slot, and the merge is done per lane.
- R4: While cen_n is 1, a rising edge has no effect. All pipeline state, memory contents, rdata and rd_valid hold, and the command inputs and wdata are ignored. Enabled-edge counting resumes when cen_n returns to 0.
- R5: A load cycle (adv=0) issues an operation only when ce1_n=0, ce2=1 and ce3_n=0. Any other combination is a no-op: memory is unchanged and no read-valid results.
- R6: rd_valid is low after the edge at which write data is sampled, so the block never drives the bus while data comes in.
- R7: With adv=1, the block issues the next beat of the burst last loaded. That beat has the same read/write type, the same bw_n and the same upper address bits as the load, and only the two low address bits change. An advance after a no-op load is itself a no-op.
- R8: The burst order is sampled at load. With burst_ilv=0 the low bits of beat n (n=0..3, wrapping) are (start+n) mod 4. With burst_ilv=1 they are start XOR n.
- R9: While oe_n is 1, rd_valid is 0. rdata and the pipeline still advance as they would otherwise.
- R10: After reset the pipeline is empty, no burst is active, and rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of pipeline state |
| cen_n | input | 1 | Active-low clock enable; 1 freezes the block |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new command |
| we_n | input | 1 | Active-low write strobe (load cycles) |
| bw_n | input | LANES | Active-low lane write selects (load cycles) |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Command address |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after the write command |
| oe_n | input | 1 | Active-low output enable; masks rd_valid only |
| rdata | output | LANES*LANE_W | Registered read data |
| rd_valid | output | 1 | rdata holds a read result and the bus is driven |

## Verification
Every result is due a fixed number of enabled edges after its command. Read data and the read-valid flag are due after the second enabled edge, and write data is consumed at that same edge. Stalled edges do not count toward the two. The bench keeps a behavioural reference that is advanced only on enabled edges. It holds a two-deep history of issued commands and a reference memory updated when each write's data slot arrives. After every edge, the bench compares rd_valid and, when a read is due, rdata at the following falling edge. Each result is therefore checked in exactly the cycle it appears, under stalls, bursts, deselects and masked outputs.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   localparam int BEAT_W = 2;

   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } beat_order_e;

   // low address bits of beat n for a burst started at 'start'
   function automatic logic [BEAT_W-1:0] beat_lo(input logic [BEAT_W-1:0] start,
                                                 input logic [BEAT_W-1:0] n,
                                                 input beat_order_e ord);
      if (ord == ORD_XOR) return start ^ n;
      return start + n;
   endfunction

endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sel,
   input  logic              adv,
   input  logic              we_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ilv,
   output logic              cmd_vld,
   output logic              cmd_wr,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [LANES-1:0]  cmd_bw_n
);

   localparam int HI_W = ADDR_W - BEAT_W;

   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("zt_burst_gen: ADDR_W must exceed the beat field width");
   end

   logic              act_q;
   logic              wr_q;
   logic [LANES-1:0]  bw_q;
   logic [HI_W-1:0]   hi_q;
   logic [BEAT_W-1:0] start_q;
   logic [BEAT_W-1:0] cnt_q;
   beat_order_e       ord_q;
   logic [BEAT_W-1:0] cnt_nx;

   assign cnt_nx = cnt_q + BEAT_W'(1);

   always_comb begin
      if (!adv) begin
         cmd_vld  = sel;
         cmd_wr   = !we_n;
         cmd_addr = addr;
         cmd_bw_n = bw_n;
      end else begin
         cmd_vld  = act_q;
         cmd_wr   = wr_q;
         cmd_addr = {hi_q, beat_lo(start_q, cnt_nx, ord_q)};
         cmd_bw_n = bw_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         wr_q    <= 1'b0;
         bw_q    <= '1;
         hi_q    <= '0;
         start_q <= '0;
         cnt_q   <= '0;
         ord_q   <= ORD_LINEAR;
      end else if (en) begin
         if (!adv) begin
            act_q   <= sel;
            wr_q    <= !we_n;
            bw_q    <= bw_n;
            hi_q    <= addr[ADDR_W-1:BEAT_W];
            start_q <= addr[BEAT_W-1:0];
            cnt_q   <= '0;
            ord_q   <= ilv ? ORD_XOR : ORD_LINEAR;
         end else begin
            cnt_q   <= cnt_nx;
         end
      end
   end

endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              in_vld,
   input  logic              in_wr,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [LANES-1:0]  in_bw_n,
   output logic              s1_vld,
   output logic              s1_wr,
   output logic [ADDR_W-1:0] s1_addr,
   output logic              s2_vld,
   output logic              s2_wr,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_bw_n
);

   logic [LANES-1:0] s1_bw_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_wr   <= 1'b0;
         s1_addr <= '0;
         s1_bw_n <= '1;
         s2_vld  <= 1'b0;
         s2_wr   <= 1'b0;
         s2_addr <= '0;
         s2_bw_n <= '1;
      end else if (en) begin
         s1_vld  <= in_vld;
         s1_wr   <= in_wr;
         s1_addr <= in_addr;
         s1_bw_n <= in_bw_n;
         s2_vld  <= s1_vld;
         s2_wr   <= s1_wr;
         s2_addr <= s1_addr;
         s2_bw_n <= s1_bw_n;
      end
   end

   // R3: stage two always carries what stage one held one enabled edge earlier
   a_r3_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (s2_vld == $past(s1_vld)) && (s2_addr == $past(s1_addr)));

endmodule

// File: rtl/zt_store.sv
module zt_store #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic [ADDR_W-1:0]       s1_addr,
   input  logic                    s2_vld,
   input  logic                    s2_wr,
   input  logic [ADDR_W-1:0]       s2_addr,
   input  logic [LANES-1:0]        s2_bw_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata_q,
   output logic                    rd_q
);

   localparam int DATA_W = LANES * LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   if (LANE_W < 2) begin : g_bad_lane
      $error("zt_store: LANE_W must be at least 2");
   end
   if (DEPTH * DATA_W > 65536) begin : g_bad_size
      $error("zt_store: array too large for a model");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] early_q;
   logic              lw_vld;
   logic [ADDR_W-1:0] lw_addr;
   logic [LANES-1:0]  lw_bw_n;
   logic [DATA_W-1:0] lw_data;
   logic [DATA_W-1:0] merged;
   logic              commit;
   logic              rd_due;
   logic              hit;

   assign commit = en && s2_vld && s2_wr;
   assign rd_due = s2_vld && !s2_wr;
   assign hit    = lw_vld && (lw_addr == s2_addr);

   // array write and early read, no reset on storage
   always_ff @(posedge clk) begin
      if (en) begin
         early_q <= mem[s1_addr];
         if (s2_vld && s2_wr) begin
            for (int i = 0; i < LANES; i++) begin
               if (!s2_bw_n[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
         end
      end
   end

   // record of the write committed at the previous enabled edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lw_vld  <= 1'b0;
         lw_addr <= '0;
         lw_bw_n <= '1;
         lw_data <= '0;
      end else if (en) begin
         lw_vld  <= s2_vld && s2_wr;
         lw_addr <= s2_addr;
         lw_bw_n <= s2_bw_n;
         lw_data <= wdata;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign merged[g*LANE_W +: LANE_W] = (hit && !lw_bw_n[g]) ?
         lw_data[g*LANE_W +: LANE_W] : early_q[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
         rd_q    <= 1'b0;
      end else if (en) begin
         rd_q <= rd_due;
         if (rd_due) rdata_q <= merged;
      end
   end

   // R6: no read-valid in the slot where write data is taken
   a_r6_quiet_on_wdata: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !rd_q);

   // R4: a stalled edge leaves the output register untouched
   a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(rdata_q) && $stable(rd_q));

   // R1: a read reaching stage two yields a valid output on the next enabled edge
   a_r1_rd_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rd_due) |=> rd_q);

endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cen_n,
   input  logic                    ce1_n,
   input  logic                    ce2,
   input  logic                    ce3_n,
   input  logic                    adv,
   input  logic                    we_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    burst_ilv,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    oe_n,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rd_valid
);

   localparam int HI_W = ADDR_W - BEAT_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("zt_sram: LANES must be at least 1");
   end

   logic              en;
   logic              sel;
   logic              c_vld, c_wr;
   logic [ADDR_W-1:0] c_addr;
   logic [LANES-1:0]  c_bw_n;
   logic              s1_vld, s1_wr;
   logic [ADDR_W-1:0] s1_addr;
   logic              s2_vld, s2_wr;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_bw_n;
   logic              rd_q;

   assign en  = !cen_n;
   assign sel = !ce1_n && ce2 && !ce3_n;

   zt_burst_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) burst_i (
      .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .adv(adv), .we_n(we_n),
      .bw_n(bw_n), .addr(addr), .ilv(burst_ilv),
      .cmd_vld(c_vld), .cmd_wr(c_wr), .cmd_addr(c_addr), .cmd_bw_n(c_bw_n));

   zt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) pipe_i (
      .clk(clk), .rst_n(rst_n), .en(en),
      .in_vld(c_vld), .in_wr(c_wr), .in_addr(c_addr), .in_bw_n(c_bw_n),
      .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr),
      .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n));

   zt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) store_i (
      .clk(clk), .rst_n(rst_n), .en(en), .s1_addr(s1_addr),
      .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n),
      .wdata(wdata), .rdata_q(rdata), .rd_q(rd_q));

   assign rd_valid = rd_q && !oe_n;

   // R5: a load with any chip select inactive leaves stage one empty
   a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv && !sel) |=> !s1_vld);

   // R7: an advance behind a live command keeps its type and upper address
   a_r7_keep_type: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv && s1_vld) |=> s1_vld && (s1_wr == $past(s1_wr)) &&
         (s1_addr[ADDR_W-1 -: HI_W] == $past(s1_addr[ADDR_W-1 -: HI_W])));

   // R7: an advance behind an empty stage stays empty
   a_r7_dead_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv && !s1_vld) |=> !s1_vld);

endmodule

// File: tb/zt_sram_tb_top.sv
module zt_sram_tb_top;

   localparam int AW = 8;
   localparam int LN = 4;
   localparam int LW = 9;
   localparam int DW = LN * LW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cen_n, ce1_n, ce2, ce3_n, adv, we_n, burst_ilv, oe_n;
   logic [LN-1:0] bw_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata;
   logic          rd_valid;

   always #4 clk = ~clk;

   zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
      .ce3_n(ce3_n), .adv(adv), .we_n(we_n), .bw_n(bw_n), .burst_ilv(burst_ilv),
      .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rd_valid(rd_valid));

   int n_chk = 0;
   int n_bad = 0;
   string cur_req = "R10";

   // reference state
   logic [DW-1:0] refmem [1 << AW];
   bit            c1v, c1w, c2v, c2w;
   int            c1a, c2a;
   logic [LN-1:0] c1b, c2b;
   bit            b_act, b_wr, b_ilv;
   int            b_base, b_cnt;
   logic [LN-1:0] b_bw;
   bit            exp_raw;
   logic [DW-1:0] exp_data;

   task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // sel: 0 all chip selects active, 1/2/3 one of them inactive
   task automatic step(input bit cen, input int sel, input bit adv_i, input bit wr,
                       input logic [LN-1:0] bw, input int a, input bit ilv, input bit oe);
      bit nv, nw;
      int na, lo;
      logic [LN-1:0] nb;
      cen_n = cen; ce1_n = (sel == 1); ce2 = (sel != 2); ce3_n = (sel == 3);
      adv = adv_i; we_n = !wr; bw_n = bw; addr = AW'(a); burst_ilv = ilv; oe_n = oe;
      wdata = DW'({$urandom(), $urandom()});
      if (!cen) begin
         if (!adv_i) begin
            nv = (sel == 0); nw = wr; na = a; nb = bw;
            b_act = nv; b_wr = wr; b_bw = bw; b_base = a; b_cnt = 0; b_ilv = ilv;
         end else begin
            b_cnt = (b_cnt + 1) % 4;
            lo = b_ilv ? ((b_base & 3) ^ b_cnt) : (((b_base & 3) + b_cnt) % 4);
            nv = b_act; nw = b_wr; na = (b_base & ~3) | lo; nb = b_bw;
         end
         if (c2v && c2w)
            for (int i = 0; i < LN; i++)
               if (!c2b[i]) refmem[c2a][i*LW +: LW] = wdata[i*LW +: LW];
         exp_raw = c2v && !c2w;
         if (exp_raw) exp_data = refmem[c2a];
         c2v = c1v; c2w = c1w; c2a = c1a; c2b = c1b;
         c1v = nv;  c1w = nw;  c1a = na;  c1b = nb;
      end
      @(posedge clk);
      @(negedge clk);
      chk(rd_valid === (exp_raw && !oe), "rd_valid", DW'(rd_valid), DW'(exp_raw && !oe));
      if (exp_raw) chk(rdata === exp_data, "rdata", rdata, exp_data);
   endtask

   task automatic wr_(input int a, input logic [LN-1:0] bw);
      step(0, 0, 0, 1, bw, a, 0, 0);
   endtask
   task automatic rd_(input int a);
      step(0, 0, 0, 0, '1, a, 0, 0);
   endtask
   task automatic nop_();
      step(0, 1, 0, 0, '1, 0, 0, 0);
   endtask

   bit done = 0;

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      c1v = 0; c2v = 0; c1w = 0; c2w = 0; c1a = 0; c2a = 0; c1b = '1; c2b = '1;
      b_act = 0; b_wr = 0; b_ilv = 0; b_base = 0; b_cnt = 0; b_bw = '1;
      exp_raw = 0; exp_data = '0;
      rst_n = 0; cen_n = 0; ce1_n = 1; ce2 = 1; ce3_n = 0; adv = 0; we_n = 1;
      bw_n = '1; burst_ilv = 0; addr = '0; wdata = '0; oe_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R10: empty after reset
      cur_req = "R10";
      chk(rd_valid === 1'b0, "reset rd_valid", DW'(rd_valid), '0);
      nop_(); nop_();

      // R2: fill with full-lane writes, then R1 read back
      cur_req = "R2";
      for (int a = 0; a < 32; a++) wr_(a, '0);
      nop_(); nop_();
      cur_req = "R1";
      for (int a = 0; a < 32; a++) rd_(a);
      nop_(); nop_();

      // R2: partial lanes (lanes 0 and 2)
      cur_req = "R2";
      wr_(5, 4'b1010); nop_(); nop_(); rd_(5); nop_(); nop_();

      // R3: back-to-back mixes to one address
      cur_req = "R3";
      wr_(7, '0); rd_(7); wr_(7, 4'b0011); rd_(7); rd_(7);
      wr_(8, 4'b1110); wr_(8, 4'b0111); rd_(8); wr_(9, 4'b0101); rd_(9); rd_(8);
      nop_(); nop_();
      for (int k = 0; k < 300; k++) begin
         if ($urandom_range(0, 1) != 0) wr_($urandom_range(0, 15), LN'($urandom()));
         else rd_($urandom_range(0, 15));
      end
      nop_(); nop_();

      // R4: stalls in a read and between a write command and its data
      cur_req = "R4";
      rd_(3);
      step(1, 0, 0, 1, '0, 3, 0, 0);
      step(1, 0, 0, 1, '0, 3, 0, 0);
      nop_();
      step(1, 0, 1, 1, '0, 3, 0, 0);
      nop_(); nop_();
      wr_(4, '0);
      step(1, 0, 0, 0, '1, 4, 0, 0);
      nop_();
      step(1, 0, 0, 1, '0, 4, 0, 0);
      rd_(4);
      step(1, 0, 0, 0, '1, 0, 0, 0);
      nop_(); nop_(); nop_();

      // R5: deselected loads do nothing
      cur_req = "R5";
      for (int s = 1; s < 4; s++) begin
         step(0, s, 0, 1, '0, 9, 0, 0);
         step(0, s, 0, 0, '1, 9, 0, 0);
      end
      nop_(); nop_(); rd_(9); nop_(); nop_();

      // R6: write slot between two reads
      cur_req = "R6";
      rd_(1); wr_(2, '0); rd_(3); wr_(2, 4'b1100); wr_(1, '0); rd_(2);
      nop_(); nop_();

      // R8: linear and interleaved read bursts
      cur_req = "R8";
      step(0, 0, 0, 0, '1, 18, 0, 0);
      for (int k = 0; k < 3; k++) step(0, 1, 1, 1, '0, 0, 1, 0);
      step(0, 0, 0, 0, '1, 17, 1, 0);
      for (int k = 0; k < 5; k++) step(0, 1, 1, 1, '0, 0, 0, 0);
      nop_(); nop_();

      // R7: write burst keeps lane selects, dead burst after deselect
      cur_req = "R7";
      step(0, 0, 0, 1, 4'b1001, 20, 0, 0);
      for (int k = 0; k < 3; k++) step(0, 0, 1, 0, '1, 0, 0, 0);
      step(0, 0, 0, 0, '1, 22, 1, 0);
      for (int k = 0; k < 3; k++) step(0, 0, 1, 1, '0, 0, 0, 0);
      step(0, 2, 0, 1, '0, 24, 0, 0);
      step(0, 0, 1, 1, '0, 24, 0, 0);
      step(0, 0, 1, 1, '0, 24, 0, 0);
      nop_(); nop_();
      for (int a = 20; a < 28; a++) rd_(a);
      nop_(); nop_();

      // R9: output enable masks the flag only
      cur_req = "R9";
      step(0, 0, 0, 0, '1, 10, 0, 1);
      step(0, 0, 0, 0, '1, 11, 0, 1);
      step(0, 1, 0, 0, '1, 0, 0, 1);
      step(0, 1, 0, 0, '1, 0, 0, 0);
      nop_();

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule